// File: doc/BRIEF.md
# Banked Message FIFO with Digest Return for Selectable Hash Cores

This block connects a controller that moves 32-bit words to a group of hash cores, of which exactly one is active at a time. Message words from the controller are stored in two banks, even and odd, written in turn. The selected core pulls the message back out either as 64-bit words (both banks read together) or as 32-bit words (banks read in turn), so one store serves both kinds of core without reordering data.

A request line tells the controller that the store is running low and should be refilled. The running core returns its result as eight 32-bit words into a small digest buffer; an acknowledge line then tells the controller that the result is waiting, and it stays up until the controller has read all eight words back in order. A one-hot enable vector keeps every core except the selected one switched off. The selection may only be changed while the store is empty and no hash is in progress.

Top module: `hash_io_fifo`

## Requirements
- R1: After reset `req` is 1, `ack` is 0, `core_valid` is 0 and `core_en` selects core 0 (value 1).
- R2: Incoming words go to the even bank first, then alternate with the odd bank; in 32-bit mode the core receives them in arrival order in `core_data[31:0]` with `core_data[63:32]` zero.
- R3: With the wide core selected (index `WIDE_CORE`, default 3) `core_valid` is high only while both banks hold a word, and `core_data` carries the earlier word in bits 31:0 and the later word in bits 63:32.
- R4: `req` is 1 while either bank holds `AE_LEVEL` (default 4) words or fewer, and 0 once both banks hold more.
- R5: `ack` rises in the cycle after the eighth digest word is accepted during a running hash (digest writes outside a running hash are dropped); `dig_rdata` then shows the words in write order, one per `dig_rd`, and `ack` falls after the eighth read.
- R6: A select request takes effect only when both banks are empty, no hash is running, no write arrives in the same cycle and the index is below `NUM_CORES`; any other request leaves `core_en` unchanged.
- R7: `core_en` is always one-hot, with its single set bit at the selected core index.
- R8: Each bank holds `MSG_BYTES/8` words (252 by default, 504 words overall); a write aimed at a full bank is dropped and leaves the stored words unchanged.
- R9: A write and a core read in the same cycle both take effect, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Controller writes a message word |
| wr_data | input | 32 | Message word from the controller |
| req | output | 1 | Refill request, store low |
| sel_wr | input | 1 | Request to change the selected core |
| sel_val | input | $clog2(NUM_CORES) | Requested core index |
| core_en | output | NUM_CORES | One-hot core enables |
| core_rd | input | 1 | Active core takes the presented word |
| core_valid | output | 1 | A word is presented to the core |
| core_data | output | 64 | Word presented to the core |
| hash_start | input | 1 | Marks the start of a hash run |
| dig_we | input | 1 | Active core writes a digest word |
| dig_wdata | input | 32 | Digest word from the core |
| ack | output | 1 | Digest complete and waiting |
| dig_rd | input | 1 | Controller takes the current digest word |
| dig_rdata | output | 32 | Current digest word |

## Verification
The controller writing a word and the core taking a word can fall in the same cycle, and both move the bank pointers and counts. The bench provokes this in 32-bit mode with words already split across both banks, raising `wr_valid` and `core_rd` on one edge, then drains the store and judges by the full arrival order of the remaining words and by `core_valid` falling exactly after the last one. A select request that coincides with a running hash or a non-empty store is likewise provoked and judged at `core_en`.

// File: rtl/hash_io_fifo.sv
module hash_io_fifo #(
  parameter int MSG_BYTES = 2016,
  parameter int DIG_BYTES = 32,
  parameter int NUM_CORES = 5,
  parameter int WIDE_CORE = 3,
  parameter int AE_LEVEL  = 4,
  localparam int SW = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [31:0]          wr_data,
  output logic                 req,
  input  logic                 sel_wr,
  input  logic [SW-1:0]        sel_val,
  output logic [NUM_CORES-1:0] core_en,
  input  logic                 core_rd,
  output logic                 core_valid,
  output logic [63:0]          core_data,
  input  logic                 hash_start,
  input  logic                 dig_we,
  input  logic [31:0]          dig_wdata,
  output logic                 ack,
  input  logic                 dig_rd,
  output logic [31:0]          dig_rdata
);
  localparam int DEPTH = MSG_BYTES / 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int DW    = DIG_BYTES / 4;
  localparam int DAW   = $clog2(DW);

  logic [31:0] ebank [DEPTH];
  logic [31:0] obank [DEPTH];
  logic [31:0] dbuf  [DW];
  logic [AW-1:0] ewp, erp, owp, orp;
  logic [CW-1:0] ecnt, ocnt;
  logic [DAW-1:0] dwp, drp;
  logic wph, rph, busy;
  logic [SW-1:0] sel;

  wire wide   = (sel == SW'(WIDE_CORE));
  wire e_ne   = (ecnt != '0);
  wire o_ne   = (ocnt != '0);
  wire empty  = !e_ne && !o_ne;
  wire e_push = wr_valid && !wph && (ecnt != CW'(DEPTH));
  wire o_push = wr_valid &&  wph && (ocnt != CW'(DEPTH));
  wire pop    = core_rd && core_valid;
  wire e_pop  = pop && (wide || !rph);
  wire o_pop  = pop && (wide ||  rph);
  wire sel_ok = sel_wr && empty && !busy && !wr_valid && (32'(sel_val) < NUM_CORES);
  wire d_acc  = dig_we && busy;
  wire d_take = dig_rd && ack;

  assign core_valid = wide ? (e_ne && o_ne) : (rph ? o_ne : e_ne);
  assign core_data  = wide ? {obank[orp], ebank[erp]}
                           : {32'b0, rph ? obank[orp] : ebank[erp]};
  assign req        = (ecnt <= CW'(AE_LEVEL)) || (ocnt <= CW'(AE_LEVEL));
  assign core_en    = NUM_CORES'(1) << sel;
  assign dig_rdata  = dbuf[drp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (e_push) ebank[ewp] <= wr_data;
    if (o_push) obank[owp] <= wr_data;
    if (d_acc)  dbuf[dwp]  <= dig_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ewp <= '0; erp <= '0; owp <= '0; orp <= '0;
      ecnt <= '0; ocnt <= '0;
      wph <= 1'b0; rph <= 1'b0;
      sel <= '0; busy <= 1'b0; ack <= 1'b0;
      dwp <= '0; drp <= '0;
    end else begin
      if (e_push) ewp <= nxt(ewp);
      if (o_push) owp <= nxt(owp);
      if (e_pop)  erp <= nxt(erp);
      if (o_pop)  orp <= nxt(orp);
      ecnt <= ecnt + CW'(e_push) - CW'(e_pop);
      ocnt <= ocnt + CW'(o_push) - CW'(o_pop);
      if (sel_ok) begin
        sel <= sel_val;
        wph <= 1'b0;
        rph <= 1'b0;
      end else begin
        if (e_push || o_push) wph <= !wph;
        if (pop && !wide)     rph <= !rph;
      end
      if (hash_start && !busy && !ack) busy <= 1'b1;
      if (d_acc) begin
        if (dwp == DAW'(DW - 1)) begin
          dwp  <= '0;
          busy <= 1'b0;
          ack  <= 1'b1;
        end else begin
          dwp <= dwp + 1'b1;
        end
      end
      if (d_take) begin
        if (drp == DAW'(DW - 1)) begin
          drp <= '0;
          ack <= 1'b0;
        end else begin
          drp <= drp + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hash_io_fifo_chk.sv
module hash_io_fifo_chk #(
  parameter int NUM_CORES = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_en,
  input logic                 req,
  input logic                 core_valid,
  input logic                 core_rd,
  input logic [63:0]          core_data,
  input logic                 ack,
  input logic                 dig_we,
  input logic                 dig_rd,
  input logic                 busy
);
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(core_en));  // R7
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(core_en));  // R6
  AST_REQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> core_valid);  // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && !core_rd) |=> (core_valid && $stable(core_data)));  // R9
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(dig_we));  // R5
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> $past(dig_rd));  // R5
endmodule

bind hash_io_fifo hash_io_fifo_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .req(req),
  .core_valid(core_valid), .core_rd(core_rd), .core_data(core_data),
  .ack(ack), .dig_we(dig_we), .dig_rd(dig_rd), .busy(busy)
);

// File: tb/hash_io_fifo_test.sv
module hash_io_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, sel_wr = 1'b0, core_rd = 1'b0;
  logic hash_start = 1'b0, dig_we = 1'b0, dig_rd = 1'b0;
  logic [31:0] wr_data = '0, dig_wdata = '0;
  logic [2:0] sel_val = '0;
  logic req, core_valid, ack;
  logic [4:0] core_en;
  logic [63:0] core_data;
  logic [31:0] dig_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hash_io_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .req(req),
    .sel_wr(sel_wr), .sel_val(sel_val), .core_en(core_en), .core_rd(core_rd),
    .core_valid(core_valid), .core_data(core_data), .hash_start(hash_start),
    .dig_we(dig_we), .dig_wdata(dig_wdata), .ack(ack), .dig_rd(dig_rd),
    .dig_rdata(dig_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    wr_valid = 1'b1; wr_data = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop32(input logic [31:0] w, input string tag);
    chk(core_valid && core_data == {32'b0, w}, tag, core_data, {32'b0, w});
    core_rd = 1'b1;
    @(negedge clk);
    core_rd = 1'b0;
  endtask

  task automatic pop64(input logic [63:0] w, input string tag);
    chk(core_valid && core_data == w, tag, core_data, w);
    core_rd = 1'b1;
    @(negedge clk);
    core_rd = 1'b0;
  endtask

  task automatic select(input logic [2:0] v);
    sel_wr = 1'b1; sel_val = v;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk(req == 1'b1, "R1 req", 64'(req), 64'd1);
    chk(ack == 1'b0, "R1 ack", 64'(ack), 64'd0);
    chk(core_valid == 1'b0, "R1 valid", 64'(core_valid), 64'd0);
    chk(core_en == 5'b00001, "R1 R7 enable", 64'(core_en), 64'd1);
  endtask

  task automatic t_narrow;
    for (int i = 0; i < 6; i++) push(32'hA000_0000 + i);
    chk(req == 1'b1, "R4 six words", 64'(req), 64'd1);
    for (int i = 0; i < 6; i++) pop32(32'hA000_0000 + i, "R2 order");
    chk(core_valid == 1'b0, "R2 drained", 64'(core_valid), 64'd0);
  endtask

  task automatic t_req;
    for (int i = 0; i < 9; i++) push(32'hB000_0000 + i);
    chk(req == 1'b1, "R4 nine words", 64'(req), 64'd1);
    push(32'hB000_0009);
    chk(req == 1'b0, "R4 ten words", 64'(req), 64'd0);
    pop32(32'hB000_0000, "R4 pop");
    chk(req == 1'b1, "R4 after pop", 64'(req), 64'd1);
    for (int i = 1; i < 10; i++) pop32(32'hB000_0000 + i, "R4 drain");
  endtask

  task automatic t_digest;
    dig_we = 1'b1; dig_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    dig_we = 1'b0;
    hash_start = 1'b1;
    @(negedge clk);
    hash_start = 1'b0;
    select(3'd2);
    chk(core_en == 5'b00001, "R6 busy select", 64'(core_en), 64'd1);
    for (int k = 0; k < 8; k++) begin
      chk(ack == 1'b0, "R5 ack early", 64'(ack), 64'd0);
      dig_we = 1'b1; dig_wdata = 32'hD000_0000 + k;
      @(negedge clk);
      dig_we = 1'b0;
    end
    chk(ack == 1'b1, "R5 ack set", 64'(ack), 64'd1);
    for (int k = 0; k < 8; k++) begin
      chk(ack == 1'b1, "R5 ack held", 64'(ack), 64'd1);
      chk(dig_rdata == 32'hD000_0000 + k, "R5 digest word", 64'(dig_rdata), 64'(32'hD000_0000 + k));
      dig_rd = 1'b1;
      @(negedge clk);
      dig_rd = 1'b0;
    end
    chk(ack == 1'b0, "R5 ack clear", 64'(ack), 64'd0);
  endtask

  task automatic t_sel_ignore;
    push(32'hC000_0001);
    select(3'd3);
    chk(core_en == 5'b00001, "R6 nonempty select", 64'(core_en), 64'd1);
    pop32(32'hC000_0001, "R6 word kept");
    select(3'd7);
    chk(core_en == 5'b00001, "R6 bad index", 64'(core_en), 64'd1);
  endtask

  task automatic t_wide;
    select(3'd3);
    chk(core_en == 5'b01000, "R6 R7 wide select", 64'(core_en), 64'd8);
    push(32'hE000_0000);
    chk(core_valid == 1'b0, "R3 half word", 64'(core_valid), 64'd0);
    push(32'hE000_0001);
    push(32'hE000_0002);
    push(32'hE000_0003);
    pop64({32'hE000_0001, 32'hE000_0000}, "R3 pair 0");
    pop64({32'hE000_0003, 32'hE000_0002}, "R3 pair 1");
    chk(core_valid == 1'b0, "R3 drained", 64'(core_valid), 64'd0);
    select(3'd0);
    chk(core_en == 5'b00001, "R7 back to 0", 64'(core_en), 64'd1);
  endtask

  task automatic t_simul;
    for (int i = 0; i < 5; i++) push(32'h5000_0000 + i);
    chk(core_valid && core_data == 64'h5000_0000, "R9 head", core_data, 64'h5000_0000);
    wr_valid = 1'b1; wr_data = 32'h5000_0005; core_rd = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; core_rd = 1'b0;
    for (int i = 1; i < 6; i++) pop32(32'h5000_0000 + i, "R9 order");
    chk(core_valid == 1'b0, "R9 drained", 64'(core_valid), 64'd0);
  endtask

  task automatic t_full;
    int bad = 0;
    for (int i = 0; i < 506; i++) push(32'h1000 + i);
    chk(req == 1'b0, "R8 full req", 64'(req), 64'd0);
    for (int i = 0; i < 504; i++) begin
      if (!(core_valid && core_data == 64'(32'h1000 + i))) begin
        bad++;
        if (bad == 1) chk(1'b0, "R8 stored word", core_data, 64'(32'h1000 + i));
      end
      core_rd = 1'b1;
      @(negedge clk);
      core_rd = 1'b0;
    end
    if (bad == 0) chk(1'b1, "R8 stored words", 64'd0, 64'd0);
    chk(core_valid == 1'b0, "R8 extra dropped", 64'(core_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_req();
    t_digest();
    t_sel_ignore();
    t_wide();
    t_simul();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule